// File: doc/BRIEF.md
# Register AND Execute Unit

This unit carries out one byte-wide logical AND between an internal working register and an operand held in data memory. It accepts a 16-bit instruction word on a start strobe, checks the opcode, and builds a 12-bit data-memory address from the 8-bit file field. The upper four address bits come from one of two sources. With the bank bit clear they come from a fixed split window: low file addresses go to bank 0 and high ones go to bank 15. With the bank bit set they come from the bank-select input.

Each instruction runs through four phases: decode, read, process and write. The operand is read through a synchronous memory port. A direction bit sends the result either back to the same memory location or into the working register. Only the negative and zero status flags are updated; every other status bit is copied through unchanged. When the opcode does not match, or an extended-mode indexed access is requested, the unit raises a one-cycle indication and changes no state.

Top module: `andreg_exec`

## Requirements
- R1: The instruction executes only when bits 15..10 equal 000101b. Any other value gives a one-cycle `illegal` pulse two cycles after the start edge. In that case there is no memory read or write, and the working register and status stay unchanged.
- R2: The result is working register AND memory operand. With bit 9 (direction) at 0, the result goes into the working register and memory is not written.
- R3: With bit 9 at 1, the result is written back to the address that was read, and the working register keeps its value.
- R4: With bit 8 (bank bit) at 0, the address is {4'h0, f} when f (bits 7..0) is below 60h, and {4'hF, f} when f is 60h or above.
- R5: With bit 8 at 1, the address is {bank_sel, f}.
- R6: On completion, status bit 4 takes result bit 7 and status bit 2 is set exactly when the result is 00h. Bits 3, 1 and 0 are copied from `status_in`.
- R7: When `ext_mode` is 1, bit 8 is 0 and f is at most 5Fh, the unit gives a one-cycle `unsupported` pulse two cycles after the start edge and changes no state. With f at 60h or above, or with bit 8 at 1, it executes normally.
- R8: After a start edge in idle, the four phases take one cycle each. `mem_rd_en` is high in the second cycle after the start edge, and `mem_wr_en` (when writing) is high in the fourth. `done` pulses for the one cycle after that, and `busy` is high during the four phases.
- R9: `w_load` in idle loads `w_din` into the working register on the next edge. Reset clears the working register and status and returns the unit to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `instr` (honoured in idle) |
| instr | input | 16 | Instruction word |
| ext_mode | input | 1 | Extended addressing mode enabled |
| bank_sel | input | 4 | Bank-select value |
| status_in | input | 5 | Current status byte to be merged |
| w_load | input | 1 | Load working register (idle only) |
| w_din | input | 8 | Working register load value |
| mem_addr | output | 12 | Data-memory address |
| mem_rd_en | output | 1 | Synchronous read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| wreg_out | output | 8 | Working register |
| status_out | output | 5 | Updated status |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle opcode-mismatch pulse |
| unsupported | output | 1 | One-cycle indexed-mode rejection pulse |

## Verification
Address-formation faults show up at the ports as a wrong `mem_addr` during the read cycle, two cycles after start. A latched direction bit that is wrong shows up as a stray or missing write strobe in the fourth cycle. A phase counter that skips or stalls moves `done` away from the fifth cycle and shifts the read strobe. A corrupted result or flag merge appears in `wreg_out`, in memory and in `status_out` the cycle after completion. A decode fault on rejected words appears as a memory strobe, or as a working-register change, within the next two cycles.

// File: rtl/andx_pkg.sv
package andx_pkg;
    parameter int DW = 8;
    parameter int FW = 8;
    parameter int AW = 12;
    parameter int BW = AW - FW;
    parameter int IW = 16;
    parameter int SW = 5;
    parameter int OPW = 6;
    parameter logic [OPW-1:0] OPC_AND = 6'b000101;
    parameter logic [FW-1:0] WIN_SPLIT = 8'h60;
    parameter int ST_NEG = 4;
    parameter int ST_ZERO = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_Q1,
        PH_Q2,
        PH_Q3,
        PH_Q4
    } phase_e;

    typedef struct packed {
        phase_e         phase;
        logic [IW-1:0]  instr;
        logic [AW-1:0]  addr;
        logic           to_file;
        logic [DW-1:0]  res;
        logic [DW-1:0]  wreg;
        logic [SW-1:0]  stat;
        logic           done;
        logic           illegal;
        logic           unsup;
    } exec_state_t;
endpackage

// File: rtl/andx_decode.sv
module andx_decode
    import andx_pkg::*;
(
    input  logic [IW-1:0] instr,
    input  logic          ext_mode,
    output logic          opc_ok,
    output logic          to_file,
    output logic          use_bank,
    output logic [FW-1:0] faddr,
    output logic          unsup
);
    localparam int OP_LSB = IW - OPW;

    always_comb begin
        opc_ok   = (instr[IW-1:OP_LSB] == OPC_AND);
        to_file  = instr[FW+1];
        use_bank = instr[FW];
        faddr    = instr[FW-1:0];
        // indexed-offset case is rejected rather than executed
        unsup    = ext_mode && !use_bank && (faddr < WIN_SPLIT);
    end
endmodule

// File: rtl/andx_addr.sv
module andx_addr
    import andx_pkg::*;
(
    input  logic [FW-1:0] faddr,
    input  logic          use_bank,
    input  logic [BW-1:0] bank_sel,
    output logic [AW-1:0] addr
);
    localparam logic [BW-1:0] LOW_BANK  = '0;
    localparam logic [BW-1:0] HIGH_BANK = '1;

    logic [BW-1:0] win_bank;

    generate
        if (BW > 0) begin : g_window
            always_comb win_bank = (faddr < WIN_SPLIT) ? LOW_BANK : HIGH_BANK;
        end
    endgenerate

    always_comb addr = {use_bank ? bank_sel : win_bank, faddr};
endmodule

// File: rtl/andx_alu.sv
module andx_alu
    import andx_pkg::*;
(
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] res_in,
    input  logic [SW-1:0] stat_in,
    output logic [DW-1:0] and_out,
    output logic [SW-1:0] stat_out
);
    always_comb begin
        and_out           = opa & opb;
        stat_out          = stat_in;
        stat_out[ST_NEG]  = res_in[DW-1];
        stat_out[ST_ZERO] = (res_in == '0);
    end
endmodule

// File: rtl/andreg_exec.sv
module andreg_exec
    import andx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   instr,
    input  logic          ext_mode,
    input  logic [3:0]    bank_sel,
    input  logic [4:0]    status_in,
    input  logic          w_load,
    input  logic [7:0]    w_din,
    output logic [11:0]   mem_addr,
    output logic          mem_rd_en,
    input  logic [7:0]    mem_rdata,
    output logic          mem_wr_en,
    output logic [7:0]    mem_wdata,
    output logic [7:0]    wreg_out,
    output logic [4:0]    status_out,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic          unsupported
);
    exec_state_t st_q, st_d;

    logic          dec_ok, dec_to_file, dec_bank, dec_unsup;
    logic [FW-1:0] dec_f;
    logic [AW-1:0] calc_addr;
    logic [DW-1:0] alu_and;
    logic [SW-1:0] merged_stat;

    andx_decode u_dec (
        .instr    (st_q.instr),
        .ext_mode (ext_mode),
        .opc_ok   (dec_ok),
        .to_file  (dec_to_file),
        .use_bank (dec_bank),
        .faddr    (dec_f),
        .unsup    (dec_unsup)
    );

    andx_addr u_addr (
        .faddr    (dec_f),
        .use_bank (dec_bank),
        .bank_sel (bank_sel),
        .addr     (calc_addr)
    );

    andx_alu u_alu (
        .opa      (st_q.wreg),
        .opb      (mem_rdata),
        .res_in   (st_q.res),
        .stat_in  (status_in),
        .and_out  (alu_and),
        .stat_out (merged_stat)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.illegal = 1'b0;
        st_d.unsup   = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (w_load) st_d.wreg = w_din;
                if (start) begin
                    st_d.instr = instr;
                    st_d.phase = PH_Q1;
                end
            end
            PH_Q1: begin
                if (!dec_ok) begin
                    st_d.illegal = 1'b1;
                    st_d.phase   = PH_IDLE;
                end else if (dec_unsup) begin
                    st_d.unsup = 1'b1;
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.addr    = calc_addr;
                    st_d.to_file = dec_to_file;
                    st_d.phase   = PH_Q2;
                end
            end
            PH_Q2: st_d.phase = PH_Q3;
            PH_Q3: begin
                st_d.res   = alu_and;
                st_d.phase = PH_Q4;
            end
            PH_Q4: begin
                if (!st_q.to_file) st_d.wreg = st_q.res;
                st_d.stat  = merged_stat;
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr    = st_q.addr;
    assign mem_rd_en   = (st_q.phase == PH_Q2);
    assign mem_wr_en   = (st_q.phase == PH_Q4) && st_q.to_file;
    assign mem_wdata   = st_q.res;
    assign wreg_out    = st_q.wreg;
    assign status_out  = st_q.stat;
    assign busy        = (st_q.phase != PH_IDLE);
    assign done        = st_q.done;
    assign illegal     = st_q.illegal;
    assign unsupported = st_q.unsup;

    AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en, 2) && mem_addr == $past(mem_addr, 2))); // R3
    AST_WB_KEEPS_W: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> $stable(wreg_out)); // R3
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_rd_en && !mem_wr_en && $stable(wreg_out) && $stable(status_out))); // R1
    AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (!mem_rd_en && !mem_wr_en && $stable(wreg_out) && $stable(status_out))); // R7
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mem_wr_en)) |-> (status_out[ST_ZERO] == ($past(mem_wdata) == '0))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R8
endmodule

// File: tb/andreg_exec_bench.sv
module andreg_exec_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] instr;
    logic        ext_mode;
    logic [3:0]  bank_sel;
    logic [4:0]  status_in;
    logic        w_load;
    logic [7:0]  w_din;
    logic [11:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rdata;
    logic        mem_wr_en;
    logic [7:0]  mem_wdata;
    logic [7:0]  wreg_out;
    logic [4:0]  status_out;
    logic        busy, done, illegal, unsupported;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] mem [0:4095];

    always #5 clk = ~clk;

    andreg_exec u_andreg_exec (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .ext_mode(ext_mode), .bank_sel(bank_sel), .status_in(status_in),
        .w_load(w_load), .w_din(w_din), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .wreg_out(wreg_out), .status_out(status_out),
        .busy(busy), .done(done), .illegal(illegal), .unsupported(unsupported)
    );

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    end

    // observations from the last run, indexed by negedge after start
    int          rd_at, wr_at, done_at, ill_at, uns_at, busy_cnt;
    logic [11:0] rd_addr;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic d, input logic a, input logic [7:0] f);
        return {6'b000101, d, a, f};
    endfunction

    task automatic load_w(input logic [7:0] v);
        @(negedge clk);
        w_load = 1'b1; w_din = v;
        @(negedge clk);
        w_load = 1'b0;
    endtask

    task automatic run(input logic [15:0] iw);
        @(negedge clk);
        start = 1'b1; instr = iw;
        rd_at = 0; wr_at = 0; done_at = 0; ill_at = 0; uns_at = 0; busy_cnt = 0;
        rd_addr = '0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            if (busy) busy_cnt++;
            if (mem_rd_en) begin rd_at = i; rd_addr = mem_addr; end
            if (mem_wr_en) wr_at = i;
            if (done) done_at = i;
            if (illegal) ill_at = i;
            if (unsupported) uns_at = i;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R9 reset W", {8'h0, wreg_out}, 16'h0000);
        check("R9 reset status", {11'h0, status_out}, 16'h0000);
        check("R9 reset busy", {15'h0, busy}, 16'h0000);
    endtask

    task automatic t_to_w;
        mem[12'h020] = 8'hC2;
        status_in = 5'b00001;
        load_w(8'h17);
        check("R9 W load", {8'h0, wreg_out}, 16'h0017);
        run(enc(1'b0, 1'b0, 8'h20));
        check("R2 W result", {8'h0, wreg_out}, 16'h0002);
        check("R2 mem kept", {8'h0, mem[12'h020]}, 16'h00C2);
        check("R4 low window addr", {4'h0, rd_addr}, 16'h0020);
        check("R6 flags", {11'h0, status_out}, 16'h0001);
        check("R8 read cycle", rd_at[15:0], 16'd2);
        check("R8 no write", wr_at[15:0], 16'd0);
        check("R8 done cycle", done_at[15:0], 16'd5);
        check("R8 busy length", busy_cnt[15:0], 16'd4);
    endtask

    task automatic t_to_file_bank;
        mem[12'h345] = 8'h9C;
        status_in = 5'b00000;
        bank_sel = 4'h3;
        load_w(8'hF0);
        run(enc(1'b1, 1'b1, 8'h45));
        check("R5 banked addr", {4'h0, rd_addr}, 16'h0345);
        check("R3 mem result", {8'h0, mem[12'h345]}, 16'h0090);
        check("R3 W kept", {8'h0, wreg_out}, 16'h00F0);
        check("R8 write cycle", wr_at[15:0], 16'd4);
        check("R6 negative", {11'h0, status_out}, 16'h0010);
    endtask

    task automatic t_high_window_zero;
        mem[12'hF80] = 8'h0F;
        status_in = 5'b01011;
        bank_sel = 4'h7;
        run(enc(1'b1, 1'b0, 8'h80));
        check("R4 high window addr", {4'h0, rd_addr}, 16'h0F80);
        check("R3 zero written", {8'h0, mem[12'hF80]}, 16'h0000);
        check("R6 zero flag, others copied", {11'h0, status_out}, 16'h000F);
        mem[12'h05F] = 8'hFF;
        status_in = 5'b00000;
        run(enc(1'b0, 1'b0, 8'h5F));
        check("R4 split edge 5F", {4'h0, rd_addr}, 16'h005F);
        check("R2 W after edge", {8'h0, wreg_out}, 16'h00F0);
    endtask

    task automatic t_illegal;
        logic [4:0] s0;
        logic [7:0] w0;
        s0 = status_out; w0 = wreg_out;
        status_in = 5'b11111;
        run(16'h1C20);
        check("R1 illegal pulse", ill_at[15:0], 16'd2);
        check("R1 no read", rd_at[15:0], 16'd0);
        check("R1 W unchanged", {8'h0, wreg_out}, {8'h0, w0});
        check("R1 status unchanged", {11'h0, status_out}, {11'h0, s0});
        check("R1 no done", done_at[15:0], 16'd0);
    endtask

    task automatic t_unsup;
        logic [4:0] s0;
        logic [7:0] w0;
        s0 = status_out; w0 = wreg_out;
        ext_mode = 1'b1;
        mem[12'h05F] = 8'h33;
        run(enc(1'b1, 1'b0, 8'h5F));
        check("R7 unsupported pulse", uns_at[15:0], 16'd2);
        check("R7 no read", rd_at[15:0], 16'd0);
        check("R7 mem unchanged", {8'h0, mem[12'h05F]}, 16'h0033);
        check("R7 W unchanged", {8'h0, wreg_out}, {8'h0, w0});
        check("R7 status unchanged", {11'h0, status_out}, {11'h0, s0});
        mem[12'hF60] = 8'h3C;
        status_in = 5'b00000;
        run(enc(1'b0, 1'b0, 8'h60));
        check("R7 ext high f executes", {4'h0, rd_addr}, 16'h0F60);
        check("R7 ext high f result", {8'h0, wreg_out}, 16'h0030);
        bank_sel = 4'hA;
        mem[12'hA10] = 8'h20;
        run(enc(1'b0, 1'b1, 8'h10));
        check("R7 ext banked executes", {4'h0, rd_addr}, 16'h0A10);
        check("R7 ext banked result", {8'h0, wreg_out}, 16'h0020);
        check("R7 no pulse when banked", uns_at[15:0], 16'd0);
        ext_mode = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        rst_n = 1'b0; start = 1'b0; instr = '0; ext_mode = 1'b0;
        bank_sel = '0; status_in = '0; w_load = 1'b0; w_din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_to_w();
        t_to_file_bank();
        t_high_window_zero();
        t_illegal();
        t_unsup();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule